// File: doc/BRIEF.md
# Ring-Buffer DMA Drain Channel

This block is a read DMA channel that empties a ring buffer of 128-bit quadwords held in memory. A separate producer channel fills the ring and publishes its write pointer. The drain channel walks a chain of tags. Each tag gives a quadword count, a kind and a data address. The channel works out how many quadwords the producer has made available, reads at most that many, and sends them one 32-bit word at a time over a valid/ready stream. A burst that would run past the ring top is split: the words up to the top are sent first, then the rest from the ring base. Data whose address lies outside the ring is read straight through, with no occupancy check and no wrap.

When no data is available, the channel parks in a stall state and raises an empty interrupt. It resumes when the producer pointer moves. When the chain finishes, it raises a done interrupt, plus an empty interrupt if the producer pointer equals the tag address. A level output gives min(16, remaining quadwords) for the current tag.

The ring is configured by a byte base and a byte mask. The base must be aligned to the ring size, and the mask must have its low four bits clear. The ring top is base + mask + 16.

Top module: `ring_drain_dma`

## Requirements
- R1: After reset, outValid, emptyIrq and doneIrq are low, fifoLevel is 0, and no transfer runs until start is pulsed.
- R2: A start pulse fetches the tag at startAddr. In tag word 0, bits [15:0] hold the quadword count and bits [30:28] hold the kind. Tag word 1 holds the data byte address. Kinds 0 and 7 end the chain once their data is sent. After a tag is fetched, the tag address steps by 16, wrapping from the ring top to the base.
- R3: For a data address inside the ring, the occupancy in quadwords is (w − d) >> 4 when d ≤ w. Otherwise it is ((w − base) + (top − d)) >> 4, where d is the drain address and w is the producer pointer. Each burst is min(occupancy, remaining count) quadwords.
- R4: When the occupancy at the next tag or at the data address inside the ring is zero, emptyIrq pulses for one cycle. No word is then streamed until prodWrAddr changes.
- R5: A burst that crosses the ring top sends words up to top − 4 and then continues at the ring base.
- R6: A burst that ends exactly at the ring top leaves both the data and the tag address at the ring base.
- R7: Data at an address outside [base, top) is streamed linearly for the full count, with no occupancy limit and no wrap.
- R8: For kinds 1, 2, 5, 6 and 7, a tag data address below base or above base + mask is replaced by base + (address & mask). Other kinds keep the address unchanged.
- R9: After the last word of a burst read from the ring, the tag address equals the next data address.
- R10: fifoLevel equals min(16, remaining quadwords) and reads 0 once the chain ends.
- R11: At chain end, doneIrq pulses for one cycle. emptyIrq pulses in the same cycle exactly when prodWrAddr equals the tag address.
- R12: With tagXferEn high, tag words 2 and 3 are streamed with outIsTag = 1 before that tag's data.
- R13: While outValid is high and outReady is low, outValid stays high and memAddr and outData hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a chain, one-cycle pulse in idle |
| startAddr | input | ADDR_W | Byte address of the first tag |
| ringBase | input | ADDR_W | Ring base byte address |
| ringMask | input | ADDR_W | Ring byte mask (size − 16) |
| tagXferEn | input | 1 | Stream tag words 2 and 3 ahead of data |
| prodWrAddr | input | ADDR_W | Producer write pointer (byte) |
| memAddr | output | ADDR_W | Word read address to memory |
| memRdata | input | 32 | Combinational read data for memAddr |
| outValid | output | 1 | Stream word valid |
| outReady | input | 1 | Consumer accepts word |
| outData | output | 32 | Stream word |
| outIsTag | output | 1 | Stream word comes from a tag |
| emptyIrq | output | 1 | Ring-empty interrupt pulse |
| doneIrq | output | 1 | Chain-done interrupt pulse |
| fifoLevel | output | 5 | min(16, remaining quadwords) |

## Verification
The hardest case to reach is a ring that empties in the middle of a tag's data and is then refilled across the wrap. The producer pointer has to sit just past the drain address, then jump to a value numerically below it. The occupancy must then use the wrapped formula, and the resumed burst must end exactly on the ring top. The bench reaches this by placing the producer pointer before each chain, waiting for the empty pulse, and only then moving the pointer. This walks the channel through stall, wrapped occupancy, exact-top ending and the empty-at-done pulse in one chain. A second chain splits a burst across the top while under backpressure from a stalling consumer.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH_TAG,
    ST_XFER,
    ST_EMPTY_STALL
  } drainState_t;

  typedef enum logic {
    SEL_TAG,
    SEL_DATA
  } addrSel_t;

  // Tag kinds (bits [30:28] of tag word 0)
  localparam logic [2:0] KIND_LAST_REF  = 3'd0;
  localparam logic [2:0] KIND_FOLLOW    = 3'd1;
  localparam logic [2:0] KIND_JUMP      = 3'd2;
  localparam logic [2:0] KIND_REF       = 3'd3;
  localparam logic [2:0] KIND_REF_STALL = 3'd4;
  localparam logic [2:0] KIND_CALL      = 3'd5;
  localparam logic [2:0] KIND_RETURN    = 3'd6;
  localparam logic [2:0] KIND_STOP      = 3'd7;

  // Strobes from control to datapath
  typedef struct packed {
    logic     loadStart;
    logic     latchTag0;
    logic     latchTag1;
    logic     stepTag;
    logic     loadBurst;
    logic     popWord;
    logic     armStall;
    addrSel_t addrSel;
    logic [1:0] tagWord;
  } ctrlStrobe_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic qwcZero;
    logic burstZero;
    logic occZero;
    logic tagEnds;
    logic prodMoved;
    logic prodAtTag;
  } dpStatus_t;

endpackage

// File: rtl/rdma_dpath.sv
module rdma_dpath
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [ADDR_W-1:0] ringMask,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] prodWrAddr,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output dpStatus_t         status,
  output logic [4:0]        fifoLevel
);
  localparam int BW = QWC_W + 2;
  localparam logic [ADDR_W-1:0] QW_BYTES   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);
  localparam logic [QWC_W-1:0]  LEVEL_CAP  = QWC_W'(16);

  logic [ADDR_W-1:0] tagAddr, dataAddr, prodSnap;
  logic [QWC_W-1:0]  qwcLeft;
  logic [2:0]        tagKind;
  logic [BW-1:0]     burstWords;
  logic              burstInRing;

  logic [ADDR_W-1:0] ringTop, selAddr, occSel, tagField, tagStepRaw, tagStepNext;
  logic [ADDR_W-1:0] dataStep, dataNext, qwcExt;
  logic [QWC_W-1:0]  burstQ;
  logic              selInRing, kindWraps, fieldOutside;

  function automatic logic inRange(input logic [ADDR_W-1:0] a, b, t);
    return (a >= b) && (a < t);
  endfunction

  function automatic logic [ADDR_W-1:0] occOf(input logic [ADDR_W-1:0] d, w, b, t);
    if (d <= w) return (w - d) >> 4;
    else        return ((w - b) + (t - d)) >> 4;
  endfunction

  assign ringTop   = ringBase + ringMask + QW_BYTES;
  assign selAddr   = (strobe.addrSel == SEL_TAG) ? tagAddr : dataAddr;
  assign selInRing = inRange(selAddr, ringBase, ringTop);
  assign occSel    = occOf(selAddr, prodWrAddr, ringBase, ringTop);
  assign qwcExt    = ADDR_W'(qwcLeft);

  // burst length: limited by occupancy only when reading from the ring
  assign burstQ = (selInRing && (occSel < qwcExt)) ? occSel[QWC_W-1:0] : qwcLeft;

  // tag data address wrap for ring-resident kinds
  assign tagField     = memRdata[ADDR_W-1:0];
  assign kindWraps    = (tagKind == KIND_FOLLOW) || (tagKind == KIND_JUMP) ||
                        (tagKind == KIND_CALL)   || (tagKind == KIND_RETURN) ||
                        (tagKind == KIND_STOP);
  assign fieldOutside = (tagField < ringBase) || (tagField > (ringBase + ringMask));

  assign tagStepRaw  = tagAddr + QW_BYTES;
  assign tagStepNext = (tagStepRaw == ringTop) ? ringBase : tagStepRaw;
  assign dataStep    = dataAddr + WORD_BYTES;
  assign dataNext    = (burstInRing && (dataStep == ringTop)) ? ringBase : dataStep;

  assign memAddr = (strobe.addrSel == SEL_TAG) ? (tagAddr + ADDR_W'({strobe.tagWord, 2'b00}))
                                               : dataAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagAddr     <= '0;
      dataAddr    <= '0;
      prodSnap    <= '0;
      qwcLeft     <= '0;
      tagKind     <= '0;
      burstWords  <= '0;
      burstInRing <= 1'b0;
    end else begin
      if (strobe.loadStart) begin
        tagAddr <= startAddr;
        qwcLeft <= '0;
      end
      if (strobe.latchTag0) begin
        qwcLeft <= memRdata[QWC_W-1:0];
        tagKind <= memRdata[30:28];
      end
      if (strobe.latchTag1)
        dataAddr <= (kindWraps && fieldOutside) ? (ringBase + (tagField & ringMask)) : tagField;
      if (strobe.stepTag)
        tagAddr <= tagStepNext;
      if (strobe.loadBurst) begin
        burstWords  <= {burstQ, 2'b00};
        burstInRing <= selInRing;
      end
      if (strobe.popWord) begin
        dataAddr   <= dataNext;
        burstWords <= burstWords - 1'b1;
        if (dataAddr[3:2] == 2'b11) qwcLeft <= qwcLeft - 1'b1;
        if ((burstWords == BW'(1)) && burstInRing) tagAddr <= dataNext;
      end
      if (strobe.armStall)
        prodSnap <= prodWrAddr;
    end
  end

  always_comb begin
    status.qwcZero   = (qwcLeft == '0);
    status.burstZero = (burstWords == '0);
    status.occZero   = selInRing && (occSel == '0);
    status.tagEnds   = (tagKind == KIND_STOP) || (tagKind == KIND_LAST_REF);
    status.prodMoved = (prodWrAddr != prodSnap);
    status.prodAtTag = (prodWrAddr == tagAddr);
  end

  assign fifoLevel = (qwcLeft >= LEVEL_CAP) ? 5'd16 : qwcLeft[4:0];

  // R3: a loaded burst never exceeds the remaining count
  p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBurst |=> (burstWords[BW-1:2] <= $past(qwcLeft)));

  // R5: while a ring burst runs, the data address stays inside the ring
  p_inring_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (burstInRing && (burstWords != '0)) |-> ((dataAddr >= ringBase) && (dataAddr < ringTop)));

  // R9: the tag address follows the data address after a ring burst
  p_tag_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popWord && (burstWords == BW'(1)) && burstInRing) |=> (tagAddr == dataAddr));

  // R10: the count drops by one after the fourth word of a quadword
  p_qwc_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popWord && (dataAddr[3:2] == 2'b11)) |=> (qwcLeft == $past(qwcLeft) - 1'b1));

endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        tagXferEn,
  input  logic        outReady,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        outIsTag,
  output logic        emptyIrq,
  output logic        doneIrq
);
  drainState_t state, stateNext;
  logic [1:0]  tagStep, tagStepNxt;
  logic        resumeXfer, resumeXferNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tagStep    <= 2'd0;
      resumeXfer <= 1'b0;
    end else begin
      state      <= stateNext;
      tagStep    <= tagStepNxt;
      resumeXfer <= resumeXferNxt;
    end
  end

  always_comb begin
    stateNext     = state;
    tagStepNxt    = tagStep;
    resumeXferNxt = resumeXfer;
    strobe        = '0;
    strobe.addrSel = SEL_DATA;
    outValid      = 1'b0;
    outIsTag      = 1'b0;
    emptyIrq      = 1'b0;
    doneIrq       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadStart = 1'b1;
          tagStepNxt       = 2'd0;
          stateNext        = ST_FETCH_TAG;
        end
      end
      ST_FETCH_TAG: begin
        strobe.addrSel = SEL_TAG;
        strobe.tagWord = tagStep;
        unique case (tagStep)
          2'd0: begin
            if (status.occZero) begin
              strobe.armStall = 1'b1;
              emptyIrq        = 1'b1;
              resumeXferNxt   = 1'b0;
              stateNext       = ST_EMPTY_STALL;
            end else begin
              strobe.latchTag0 = 1'b1;
              tagStepNxt       = 2'd1;
            end
          end
          2'd1: begin
            strobe.latchTag1 = 1'b1;
            if (tagXferEn) begin
              tagStepNxt = 2'd2;
            end else begin
              strobe.stepTag = 1'b1;
              stateNext      = ST_XFER;
            end
          end
          default: begin
            outValid = 1'b1;
            outIsTag = 1'b1;
            if (outReady) begin
              if (tagStep == 2'd3) begin
                strobe.stepTag = 1'b1;
                stateNext      = ST_XFER;
              end else begin
                tagStepNxt = 2'd3;
              end
            end
          end
        endcase
      end
      ST_XFER: begin
        if (status.burstZero) begin
          if (status.qwcZero) begin
            if (status.tagEnds) begin
              doneIrq   = 1'b1;
              emptyIrq  = status.prodAtTag;
              stateNext = ST_IDLE;
            end else begin
              tagStepNxt = 2'd0;
              stateNext  = ST_FETCH_TAG;
            end
          end else if (status.occZero) begin
            strobe.armStall = 1'b1;
            emptyIrq        = 1'b1;
            resumeXferNxt   = 1'b1;
            stateNext       = ST_EMPTY_STALL;
          end else begin
            strobe.loadBurst = 1'b1;
          end
        end else begin
          outValid = 1'b1;
          if (outReady) strobe.popWord = 1'b1;
        end
      end
      ST_EMPTY_STALL: begin
        strobe.addrSel = resumeXfer ? SEL_DATA : SEL_TAG;
        if (status.prodMoved) begin
          tagStepNxt = 2'd0;
          stateNext  = resumeXfer ? ST_XFER : ST_FETCH_TAG;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R11: done is a single-cycle pulse and the channel is idle after it
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> (!doneIrq && (state == ST_IDLE)));

  // R4: a stall-entry empty pulse is not followed by a stream word
  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (emptyIrq && !doneIrq) |=> !outValid);

  // R4: only one empty pulse per stall entry
  p_empty_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (emptyIrq && !doneIrq) |=> !emptyIrq);

endmodule

// File: rtl/ring_drain_dma.sv
module ring_drain_dma
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [ADDR_W-1:0] ringMask,
  input  logic              tagXferEn,
  input  logic [ADDR_W-1:0] prodWrAddr,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memRdata,
  output logic              outValid,
  input  logic              outReady,
  output logic [31:0]       outData,
  output logic              outIsTag,
  output logic              emptyIrq,
  output logic              doneIrq,
  output logic [4:0]        fifoLevel
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  rdma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tagXferEn(tagXferEn),
    .outReady (outReady),
    .status   (status),
    .strobe   (strobe),
    .outValid (outValid),
    .outIsTag (outIsTag),
    .emptyIrq (emptyIrq),
    .doneIrq  (doneIrq)
  );

  rdma_dpath #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ringBase  (ringBase),
    .ringMask  (ringMask),
    .startAddr (startAddr),
    .prodWrAddr(prodWrAddr),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .status    (status),
    .fifoLevel (fifoLevel)
  );

  assign outData = memRdata;

  // R13: a stalled stream word keeps its address and kind
  p_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(memAddr) && $stable(outIsTag)));

endmodule

// File: tb/sim_ring_drain_dma.sv
`timescale 1ns/1ps
module sim_ring_drain_dma;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] startAddr = '0;
  logic [31:0] ringBase = 32'h400;
  logic [31:0] ringMask = 32'h0F0;
  logic        tagXferEn = 1'b0;
  logic [31:0] prodWrAddr = 32'h400;
  logic [31:0] memAddr, memRdata, outData;
  logic        outValid, outReady, outIsTag, emptyIrq, doneIrq;
  logic [4:0]  fifoLevel;

  logic [31:0] mem [0:1023];
  assign memRdata = mem[memAddr[11:2]];

  always #10 clk = ~clk;

  ring_drain_dma u0 (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .ringBase(ringBase), .ringMask(ringMask), .tagXferEn(tagXferEn),
    .prodWrAddr(prodWrAddr), .memAddr(memAddr), .memRdata(memRdata),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outIsTag(outIsTag), .emptyIrq(emptyIrq), .doneIrq(doneIrq),
    .fifoLevel(fifoLevel)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int emptyCnt = 0;
  int doneCnt = 0;
  bit emptyAtDone = 0;
  bit bpOn = 0;
  string curReq = "R1";
  logic [32:0] expQ[$];
  bit holdPending = 0;
  logic [31:0] heldData;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern, driven away from the sampling edge
  always @(posedge clk) begin
    #1;
    cyc++;
    outReady = bpOn ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (holdPending)
        chk(outValid && (outData == heldData), "R13", {31'd0, outValid, outData}, {32'd1, heldData});
      holdPending = outValid && !outReady;
      heldData    = outData;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, {curReq, " unexpected word"}, {31'd0, outIsTag, outData}, 64'd0);
        end else begin
          logic [32:0] e;
          e = expQ.pop_front();
          chk({outIsTag, outData} == e, curReq, {31'd0, outIsTag, outData}, {31'd0, e});
        end
      end
      if (emptyIrq) emptyCnt++;
      if (doneIrq) begin
        doneCnt++;
        emptyAtDone = emptyIrq;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  task automatic putTag(input logic [31:0] a, input logic [2:0] kind, input logic [15:0] qwc,
                        input logic [31:0] dAddr);
    mem[a[11:2]]       = {1'b0, kind, 12'h000, qwc};
    mem[a[11:2] + 1]   = dAddr;
    mem[a[11:2] + 2]   = 32'h7A600000 | a;
    mem[a[11:2] + 3]   = 32'h7B700000 | a;
  endtask

  task automatic pushRun(input logic [31:0] a, input int n, input bit isTag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = a + 32'(i * 4);
      expQ.push_back({isTag, mem[w[11:2]]});
    end
  endtask

  task automatic kick(input logic [31:0] a);
    @(posedge clk); #2;
    startAddr = a;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic waitEmpty(input int n);
    while (emptyCnt < n) @(negedge clk);
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishChain(input string req, input int expEmpty, input bit expAtDone);
    while (doneCnt < 1) @(negedge clk);
    waitCycles(2);
    chk(expQ.size() == 0, {req, " stream drained"}, 64'(expQ.size()), 64'd0);
    chk(doneCnt == 1, {"R11 done count ", req}, 64'(doneCnt), 64'd1);
    chk(emptyCnt == expEmpty, {"R4 R11 empty count ", req}, 64'(emptyCnt), 64'(expEmpty));
    chk(emptyAtDone == expAtDone, {"R11 empty at done ", req}, 64'(emptyAtDone), 64'(expAtDone));
    chk(fifoLevel == 5'd0, {"R10 level at end ", req}, 64'(fifoLevel), 64'd0);
  endtask

  task automatic clearCounts();
    emptyCnt = 0;
    doneCnt = 0;
    emptyAtDone = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE0000 | 32'(i * 4);
    outReady = 1'b1;
    waitCycles(3);
    @(posedge clk); #2;
    rstN = 1'b1;
    waitCycles(3);

    // R1: reset state, nothing runs without start
    chk(!outValid, "R1 outValid", 64'(outValid), 64'd0);
    chk(!emptyIrq && !doneIrq, "R1 irqs", {62'd0, emptyIrq, doneIrq}, 64'd0);
    chk(fifoLevel == 5'd0, "R1 level", 64'(fifoLevel), 64'd0);

    // Chain A: tag address below base wraps (R8), occupancy limit (R3),
    // empty stall mid-tag (R4), end without empty (R11)
    curReq = "R2 R3 R8";
    clearCounts();
    prodWrAddr = 32'h440;
    putTag(32'h400, 3'd1, 16'd2, 32'h010);
    putTag(32'h430, 3'd7, 16'd1, 32'h440);
    pushRun(32'h410, 8, 1'b0);
    pushRun(32'h440, 4, 1'b0);
    kick(32'h400);
    waitEmpty(1);
    waitCycles(6);
    chk(!outValid, "R4 quiet in stall", 64'(outValid), 64'd0);
    chk(expQ.size() == 4, "R4 no words during stall", 64'(expQ.size()), 64'd4);
    chk(fifoLevel == 5'd1, "R10 level in stall", 64'(fifoLevel), 64'd1);
    curReq = "R4 resume";
    prodWrAddr = 32'h460;
    finishChain("chainA", 1, 1'b0);

    // Chain B: burst split across the top (R5), tag follows data (R9),
    // empty at done (R11), under backpressure (R13)
    curReq = "R5 R9";
    clearCounts();
    bpOn = 1;
    prodWrAddr = 32'h420;
    putTag(32'h4C0, 3'd1, 16'd4, 32'h4D0);
    putTag(32'h410, 3'd7, 16'd0, 32'h000);
    pushRun(32'h4D0, 12, 1'b0);
    pushRun(32'h400, 4, 1'b0);
    kick(32'h4C0);
    finishChain("chainB", 1, 1'b1);

    // Chain C: tag words streamed (R12), address above base+mask wraps (R8),
    // wrapped occupancy after producer wraps (R3), burst ends on top (R6)
    curReq = "R12 R8 R3";
    clearCounts();
    bpOn = 0;
    tagXferEn = 1'b1;
    prodWrAddr = 32'h4F0;
    putTag(32'h480, 3'd2, 16'd3, 32'h14D0);
    putTag(32'h400, 3'd7, 16'd0, 32'h000);
    pushRun(32'h488, 2, 1'b1);
    pushRun(32'h4D0, 8, 1'b0);
    pushRun(32'h4F0, 4, 1'b0);
    pushRun(32'h408, 2, 1'b1);
    kick(32'h480);
    waitEmpty(1);
    waitCycles(4);
    chk(expQ.size() == 6, "R3 occupancy-limited burst", 64'(expQ.size()), 64'd6);
    curReq = "R6 R12";
    prodWrAddr = 32'h410;
    finishChain("chainC R6", 2, 1'b1);

    // Chain D: data outside the ring streams linearly (R7), kind 3 keeps its
    // address (R8), level saturates at 16 (R10), stall before a tag (R4)
    curReq = "R7 R8 R13";
    clearCounts();
    bpOn = 1;
    prodWrAddr = 32'h420;
    putTag(32'h410, 3'd3, 16'd20, 32'h800);
    putTag(32'h420, 3'd0, 16'd0, 32'h900);
    pushRun(32'h418, 2, 1'b1);
    pushRun(32'h800, 80, 1'b0);
    pushRun(32'h428, 2, 1'b1);
    kick(32'h410);
    while (expQ.size() > 78) @(negedge clk);
    chk(fifoLevel == 5'd16, "R10 level saturates", 64'(fifoLevel), 64'd16);
    waitEmpty(1);
    waitCycles(5);
    chk(!outValid, "R4 quiet before tag", 64'(outValid), 64'd0);
    chk(expQ.size() == 2, "R7 full count streamed", 64'(expQ.size()), 64'd2);
    curReq = "R2 R12";
    prodWrAddr = 32'h430;
    finishChain("chainD", 2, 1'b1);

    chk(expQ.size() == 0, "R2 scoreboard empty", 64'(expQ.size()), 64'd0);
    summary();
    $finish;
  end
endmodule